// File: doc/BRIEF.md
# Palette Loader and Colour Lookup

This block takes in a colour palette as a burst of 32-bit words and keeps it as a table of 12-bit colours (4 bits each of red, green and blue). Each word carries two 16-bit palette entries. The top nibble of the very first entry is a depth code, and that code sets how many words make up the burst and whether the table is used at all.

Once a burst has been fully taken in, the block acts as a colour lookup. Each cycle it turns a pixel value into a 12-bit colour, which appears on a registered output one clock later. In the 8, 4, 2 and 1 bpp depths the low byte of the pixel indexes the table. In the 16-bit depth the table is bypassed and the pixel is cut down to 4 bits per channel.

A typical use is a display pipeline that downloads its palette once with a single non-repeating transfer and then streams pixels through. The block clears the table at the start of every new burst, so colours from an earlier palette never leak into the current one.

Top module: `palette_clut`

## Requirements
- R1: Each 32-bit word holds two palette entries: bits 15:0 are entry 2k and bits 31:16 are entry 2k+1, where k is the word's position in the burst counted from 0. An entry's colour is its bits 11:0, laid out as red in 11:8, green in 7:4 and blue in 3:0. In a table depth, a lookup of index i returns the colour of entry i.
- R2: The depth code is taken from bits 15:12 of the first word of a burst. Code 3 (8 bpp, 256 entries) makes a burst of 129 words. Codes 0, 1 and 2 (1, 2 and 4 bpp, 128 entries) make a burst of 65 words. Any code of 4 or above (16 bpp, 16 entries) makes a burst of 9 words.
- R3: `load_done` is high for exactly one cycle, in the cycle after the final word of a burst is accepted. It stays low at all other times.
- R4: The final word of every burst is discarded. Its halfwords never reach the table, so with code 2 the indices 128 and 129 read as zero.
- R5: The first word of a burst clears the whole table. A lookup of an index that the current burst did not write returns 12'h000.
- R6: A pixel presented before a clock edge produces its colour on `rgb` after that edge, and the colour holds until the next edge. The latency is one cycle, and a new pixel can be given every cycle.
- R7: With a depth code of 4 or above, the table is bypassed and `rgb` = {pix[15:12], pix[10:7], pix[4:1]}, which is RGB565 cut down to 4 bits per channel.
- R8: `rgb` is 12'h000 until the first burst completes, and also from the second word of any later burst until that burst completes.
- R9: `word_ready` is high whenever reset is released. Cycles with `word_valid` low do not advance the burst.
- R10: During reset, `load_done` and `rgb` are 0 and `word_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_data | input | 32 | Palette word, two entries |
| word_valid | input | 1 | word_data holds a word this cycle |
| word_ready | output | 1 | Block can accept a word |
| load_done | output | 1 | One-cycle pulse after the final word of a burst |
| pix | input | 16 | Pixel value; the low byte is the index in table depths |
| rgb | output | 12 | Registered colour output |

## Verification
A burst counter that is off by even one word moves the `load_done` pulse by one cycle. It also shifts every entry pair, so both faults show up within the same palette load. A depth code that was decoded wrongly, or a table-clear that was missed, shows up only as colours at indices near the top of the palette that are wrong or should be zero. For that reason the bench reads back indices just below and just above each depth's entry count. A bypass or latency fault is visible at the very first pixel after `load_done`.

// File: rtl/palette_clut.sv
module palette_clut (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] word_data,
  input  logic        word_valid,
  output logic        word_ready,
  output logic        load_done,
  input  logic [15:0] pix,
  output logic [11:0] rgb
);
  localparam int ENTRIES = 256;
  localparam int IW      = $clog2(ENTRIES);

  logic [11:0]        table_q [ENTRIES];
  logic [ENTRIES-1:0] filled;
  logic               busy, loaded, bypass;
  logic [IW-1:0]      cnt, last_q;

  function automatic logic [IW-1:0] last_word(input logic [3:0] code);
    if (code == 4'd3)     return IW'(128);
    else if (code < 4'd3) return IW'(64);
    else                  return IW'(8);
  endfunction

  wire           first = word_valid && !busy;
  wire [IW-1:0]  lim   = first ? last_word(word_data[15:12]) : last_q;
  wire [IW-1:0]  k     = first ? '0 : cnt;
  wire           store = word_valid && (k < lim);
  wire           fin   = word_valid && (k == lim);
  wire [IW-1:0]  ia    = {k[IW-2:0], 1'b0};
  wire [IW-1:0]  ib    = {k[IW-2:0], 1'b1};

  assign word_ready = rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      loaded    <= 1'b0;
      bypass    <= 1'b0;
      cnt       <= '0;
      last_q    <= '0;
      load_done <= 1'b0;
    end else begin
      load_done <= fin;
      if (word_valid) begin
        if (first) begin
          last_q <= lim;
          bypass <= (word_data[15:12] > 4'd3);
          loaded <= 1'b0;
        end
        busy <= !fin;
        cnt  <= k + 1'b1;
        if (fin) loaded <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) filled <= '0;
    else if (word_valid) begin
      if (first) filled <= '0;
      if (store) begin
        filled[ia] <= 1'b1;
        filled[ib] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      table_q[ia] <= word_data[11:0];
      table_q[ib] <= word_data[27:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rgb <= '0;
    else if (!loaded) rgb <= '0;
    else if (bypass)  rgb <= {pix[15:12], pix[10:7], pix[4:1]};
    else              rgb <= filled[pix[7:0]] ? table_q[pix[7:0]] : 12'h000;
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  a_r3_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(word_valid));
  a_r8_zero_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |=> rgb == 12'h000);
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && bypass) |=> rgb == {$past(pix[15:12]), $past(pix[10:7]), $past(pix[4:1])});
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= IW'(128) || !busy);
  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n) word_ready);
endmodule

// File: tb/test_palette_clut.sv
module test_palette_clut;
  logic        clk = 0, rst_n = 0;
  logic [31:0] word_data = '0;
  logic        word_valid = 0;
  logic        word_ready, load_done;
  logic [15:0] pix = '0;
  logic [11:0] rgb;

  palette_clut i_palette_clut (
    .clk(clk), .rst_n(rst_n), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .load_done(load_done), .pix(pix), .rgb(rgb));

  always #5 clk = ~clk;

  typedef struct { logic [11:0] e; int due; string tag; } item_t;
  item_t q[$];
  item_t it;
  int checks = 0, failures = 0, cyc = 0;
  logic [11:0] mref [256];
  bit          mval [256];
  bit          mloaded = 0, mbyp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk)
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      chk(rgb === it.e, it.tag, rgb, it.e);
    end

  function automatic logic [11:0] model(input logic [15:0] p);
    if (!mloaded) return 12'h000;
    if (mbyp) return {p[15:12], p[10:7], p[4:1]};
    return mval[p[7:0]] ? mref[p[7:0]] : 12'h000;
  endfunction

  task automatic push(input logic [11:0] e, input string tag);
    item_t n;
    n.e = e; n.due = cyc + 1; n.tag = tag;
    q.push_back(n);
  endtask

  task automatic lookup(input logic [15:0] p, input string tag);
    @(negedge clk);
    pix = p;
    push(model(p), tag);
  endtask

  function automatic logic [11:0] col(input int i, input int seed);
    return 12'((i * 37 + seed * 11 + 5) & 12'hfff);
  endfunction

  task automatic load(input logic [3:0] code, input int seed, input int probe);
    int n;
    n = (code == 4'd3) ? 129 : (code < 4'd3) ? 65 : 9;
    for (int i = 0; i < 256; i++) mval[i] = 0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] lo, hi;
      lo = {(k == 0) ? code : 4'(k), col(2*k, seed)};
      hi = {4'(k + 3), col(2*k+1, seed)};
      if (k < n - 1) begin
        mref[2*k] = lo[11:0];   mval[2*k] = 1;
        mref[2*k+1] = hi[11:0]; mval[2*k+1] = 1;
      end
      if (k % 5 == 3) begin
        @(negedge clk); word_valid = 0;
      end
      @(negedge clk);
      if (k == n - 1) chk(load_done === 1'b0, "R3 early done", load_done, 0);
      word_data = {hi, lo}; word_valid = 1;
      if (k == 1) mloaded = 0;
      if (k == probe) begin pix = 16'h0005; push(12'h000, "R8 busy"); end
    end
    @(negedge clk); word_valid = 0;
    chk(load_done === 1'b1, "R2 R3 done", load_done, 1);
    @(negedge clk);
    chk(load_done === 1'b0, "R3 pulse width", load_done, 0);
    mloaded = 1;
    mbyp = (code > 4'd3);
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(load_done === 1'b0, "R10 done", load_done, 0);
    chk(rgb === 12'h000, "R10 rgb", rgb, 0);
    chk(word_ready === 1'b0, "R10 ready", word_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk(word_ready === 1'b1, "R9 ready", word_ready, 1);
    lookup(16'h0003, "R8 before load");

    load(4'd3, 1, 10);
    lookup(16'h0000, "R1 entry0");
    lookup(16'h0001, "R1 R6 entry1");
    lookup(16'h0002, "R1 R6 entry2");
    lookup(16'h0003, "R1 R6 entry3");
    lookup(16'hFF64, "R1 high byte ignored");
    lookup(16'h00C9, "R1 entry201");
    lookup(16'h00FE, "R1 entry254");
    lookup(16'h00FF, "R1 entry255");
    chk(word_ready === 1'b1, "R9 ready after load", word_ready, 1);

    load(4'd2, 2, 4);
    lookup(16'h0000, "R2 code2 entry0");
    lookup(16'h007F, "R2 code2 entry127");
    lookup(16'h0080, "R4 entry128");
    lookup(16'h0081, "R4 entry129");
    lookup(16'h00C8, "R5 stale cleared");

    load(4'd0, 3, 2);
    lookup(16'h0005, "R1 code0");
    lookup(16'h00F0, "R5 code0 unwritten");

    load(4'd1, 4, 7);
    lookup(16'h0040, "R1 code1");

    load(4'd4, 5, 3);
    lookup(16'hFFFF, "R7 ones");
    lookup(16'h0000, "R7 zero");
    lookup(16'hA5C3, "R7 pattern");
    lookup(16'h1234, "R7 pattern2");

    load(4'd9, 6, 1);
    lookup(16'h8421, "R7 R2 code9");

    load(4'd3, 7, 50);
    lookup(16'h0010, "R5 reload");
    lookup(16'h00FF, "R5 reload top");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6 queue drained", q.size(), 0);
    finish_run();
  end
endmodule